// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog that advances on its own free-running tick, so it keeps counting while the core clock is stopped in sleep. An 8-bit base counter counts watchdog ticks. Its overflow either ends the timeout interval directly or drives a prescaler that stretches the interval by a power of two. The prescaler has one owner at a time. An assignment input gives it either to the watchdog or to a general-purpose timer's clock source. When the timer owns it, the prescaler divides the timer's clock-source pulses and passes the result on as the timer's prescaled clock.

The effect of a timeout depends on the sleep-status input. A running device gets a reset request. A sleeping device gets a wake-up request and then carries on. An active-low timeout flag records that a timeout has happened. A clear strobe or a sleep-entry strobe restarts the interval and sets the flag back to 1. A configuration enable held at 0 stops the watchdog completely. All logic runs on one clock. The two tick inputs are single-cycle enables on that clock.

Top module: `wdt_prescaled`

## Requirements
- R1: While `por_n` is 0, and on the first cycle after it returns to 1, the outputs are `rst_req`=0, `wake_req`=0, `tmr_pulse`=0 and `to_n`=1. Both counters start at zero.
- R2: When `asleep` is 0, a timeout raises `rst_req` for exactly one cycle, on the cycle after the edge that sampled the final tick. `wake_req` stays 0.
- R3: When `asleep` is 1, a timeout raises `wake_req` for one cycle instead, and `rst_req` stays 0.
- R4: When `cfg_wd_en` is 0, the base counter does not advance and no timeout ever occurs, however many ticks arrive.
- R5: When `psc_to_wd` is 0, a timeout occurs on every 256th `wd_tick` counted from a clear. The ratio field has no effect on this interval.
- R6: When `psc_to_wd` is 1 and `psc_ratio` holds k (0..7), a timeout occurs on every 2^k-th base overflow. That is 256*2^k ticks after a clear.
- R7: A `clr_wd` or `sleep_enter` pulse zeroes the base counter. When `psc_to_wd` is 1 it also zeroes the prescaler. A clear in the same cycle as the final tick wins, and no timeout is produced.
- R8: When `psc_to_wd` is 0, a clear does not alter the prescaler count or the division the timer sees.
- R9: `to_n` drops to 0 in the same cycle as the timeout pulse. It returns to 1 on the cycle after a `clr_wd` or `sleep_enter` pulse.
- R10: When `psc_to_wd` is 0, `tmr_pulse` fires one cycle after every 2^k-th `tmr_tick`. When `psc_to_wd` is 1, it follows each `tmr_tick` one cycle later, with no division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wd_tick | input | 1 | Watchdog oscillator tick enable |
| tmr_tick | input | 1 | Timer clock-source pulse |
| cfg_wd_en | input | 1 | Configuration enable for the watchdog |
| psc_to_wd | input | 1 | Prescaler owner: 1 watchdog, 0 timer |
| psc_ratio | input | 3 | Prescaler ratio select k, ratio 2^k |
| clr_wd | input | 1 | Clear-watchdog strobe |
| sleep_enter | input | 1 | Sleep-entry strobe, also clears |
| asleep | input | 1 | Device sleep status |
| rst_req | output | 1 | Device reset request pulse |
| wake_req | output | 1 | Wake-up request pulse |
| to_n | output | 1 | Timeout flag, active low |
| tmr_pulse | output | 1 | Prescaled clock pulse toward the timer |

## Verification
A clear strobe and the terminal watchdog tick can arrive in the same cycle. The bench provokes this by counting 255 ticks after a clear and then asserting `clr_wd` together with the 256th tick. The judgement has two parts. No request pulse may appear on that cycle, and the next timeout must come a full 256 ticks later. A second case lets one base overflow advance the prescaler before the clear. The full 512-tick interval that follows shows that the prescaler was zeroed along with the base counter.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int BASE_W = 8,
  parameter int PSC_W  = 8,
  parameter int SEL_W  = $clog2(PSC_W)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wd_tick,
  input  logic             tmr_tick,
  input  logic             cfg_wd_en,
  input  logic             psc_to_wd,
  input  logic [SEL_W-1:0] psc_ratio,
  input  logic             clr_wd,
  input  logic             sleep_enter,
  input  logic             asleep,
  output logic             rst_req,
  output logic             wake_req,
  output logic             to_n,
  output logic             tmr_pulse
);

  logic [BASE_W-1:0] base_q;
  logic [PSC_W-1:0]  psc_q;
  logic [PSC_W-1:0]  tap_mask;
  logic              clr, base_ovf, psc_step, psc_hit, timeout;

  assign clr      = clr_wd | sleep_enter;
  assign base_ovf = cfg_wd_en & wd_tick & (&base_q);
  assign tap_mask = (PSC_W'(1) << psc_ratio) - PSC_W'(1);
  assign psc_step = psc_to_wd ? base_ovf : tmr_tick;
  assign psc_hit  = psc_step & ((psc_q & tap_mask) == tap_mask);
  assign timeout  = ~clr & (psc_to_wd ? psc_hit : base_ovf);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                  base_q <= '0;
    else if (clr)                base_q <= '0;
    else if (cfg_wd_en && wd_tick) base_q <= base_q + BASE_W'(1);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                  psc_q <= '0;
    else if (clr && psc_to_wd)   psc_q <= '0;
    else if (psc_step)           psc_q <= psc_q + PSC_W'(1);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      rst_req   <= 1'b0;
      wake_req  <= 1'b0;
      to_n      <= 1'b1;
      tmr_pulse <= 1'b0;
    end else begin
      rst_req   <= timeout & ~asleep;
      wake_req  <= timeout & asleep;
      tmr_pulse <= psc_to_wd ? tmr_tick : psc_hit;
      if (clr)          to_n <= 1'b1;
      else if (timeout) to_n <= 1'b0;
    end

  p_reset_awake_r2: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> !$past(asleep));
  p_wake_asleep_r3: assert property (@(posedge clk) disable iff (!por_n)
    wake_req |-> $past(asleep));
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!por_n)
    !(rst_req && wake_req));
  p_disabled_r4: assert property (@(posedge clk) disable iff (!por_n)
    !$past(cfg_wd_en) |-> !(rst_req || wake_req));
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!por_n)
    (clr_wd || sleep_enter) |=> !(rst_req || wake_req) && to_n);
  p_psc_zeroed_r7: assert property (@(posedge clk) disable iff (!por_n)
    ((clr_wd || sleep_enter) && psc_to_wd) |=> (psc_q == '0));
  p_flag_falls_r9: assert property (@(posedge clk) disable iff (!por_n)
    $fell(to_n) |-> (rst_req || wake_req));
  p_tmr_source_r10: assert property (@(posedge clk) disable iff (!por_n)
    tmr_pulse |-> $past(tmr_tick));

endmodule

// File: tb/wdt_prescaled_tb_top.sv
module wdt_prescaled_tb_top;
  logic clk = 0;
  always #5 clk = ~clk;

  logic por_n = 0, wd_tick = 0, tmr_tick = 0, cfg_wd_en = 1, psc_to_wd = 0;
  logic [2:0] psc_ratio = 0;
  logic clr_wd = 0, sleep_enter = 0, asleep = 0;
  logic rst_req, wake_req, to_n, tmr_pulse;

  int checks = 0, fails = 0;
  bit done = 0;

  wdt_prescaled dut_i (.clk(clk), .por_n(por_n), .wd_tick(wd_tick), .tmr_tick(tmr_tick),
    .cfg_wd_en(cfg_wd_en), .psc_to_wd(psc_to_wd), .psc_ratio(psc_ratio), .clr_wd(clr_wd),
    .sleep_enter(sleep_enter), .asleep(asleep), .rst_req(rst_req), .wake_req(wake_req),
    .to_n(to_n), .tmr_pulse(tmr_pulse));

  // {owner[31], ratio[30:28], asleep[27], expected ticks[19:0]}
  localparam logic [31:0] VEC [7] = '{
    32'h5000_0100, 32'h0800_0100, 32'h8000_0100, 32'h9000_0200,
    32'hA800_0400, 32'hB000_0800, 32'hF000_8000 };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_ticks(output int n);
    n = 0;
    wd_tick = 1;
    while (n < 40000) begin
      cyc(); n++;
      if (rst_req || wake_req) break;
    end
    wd_tick = 0;
  endtask

  task automatic clear_once();
    clr_wd = 1; cyc(); clr_wd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    cyc(); cyc();
    chk(!rst_req && !wake_req && !tmr_pulse && to_n, "R1 in reset", to_n, 1);
    por_n = 1; cyc();
    chk(!rst_req && !wake_req && !tmr_pulse && to_n, "R1 after reset", to_n, 1);

    foreach (VEC[i]) begin
      psc_to_wd = VEC[i][31];
      psc_ratio = VEC[i][30:28];
      asleep    = VEC[i][27];
      clear_once();
      chk(to_n == 1, "R9 flag after clear", to_n, 1);
      count_ticks(n);
      chk(n == int'(VEC[i][19:0]), psc_to_wd ? "R6 interval" : "R5 interval", n, int'(VEC[i][19:0]));
      chk(wake_req == asleep && rst_req == !asleep, asleep ? "R3 wake" : "R2 reset", wake_req, asleep);
      chk(to_n == 0, "R9 flag low at timeout", to_n, 0);
      cyc();
      chk(!rst_req && !wake_req, "R2 single pulse", rst_req, 0);
    end
    asleep = 0;

    sleep_enter = 1; cyc(); sleep_enter = 0;
    chk(to_n == 1, "R9 sleep entry restores flag", to_n, 1);

    // R7: clear coinciding with the terminal tick
    psc_to_wd = 0; clear_once();
    wd_tick = 1;
    for (int i = 0; i < 255; i++) cyc();
    chk(!rst_req && !wake_req, "R7 no early timeout", rst_req, 0);
    clr_wd = 1; cyc(); clr_wd = 0; wd_tick = 0;
    chk(!rst_req && !wake_req, "R7 clear wins", rst_req, 0);
    count_ticks(n);
    chk(n == 256, "R7 full interval after clear", n, 256);

    // R7: prescaler zeroed when owned by watchdog
    psc_to_wd = 1; psc_ratio = 1; clear_once();
    wd_tick = 1;
    for (int i = 0; i < 256; i++) cyc();
    wd_tick = 0;
    chk(!rst_req && !wake_req, "R6 first overflow silent", rst_req, 0);
    clear_once();
    count_ticks(n);
    chk(n == 512, "R7 prescaler cleared", n, 512);

    // R4: disabled
    cfg_wd_en = 0; psc_to_wd = 0; clear_once();
    count_ticks(n);
    chk(n == 40000 && to_n, "R4 disabled never times out", n, 40000);
    cfg_wd_en = 1;

    // R10 / R8: timer path
    psc_to_wd = 1; clear_once();
    psc_to_wd = 0; psc_ratio = 2;
    for (int i = 1; i <= 4; i++) begin
      tmr_tick = 1; cyc(); tmr_tick = 0;
      chk(tmr_pulse == (i == 4), "R10 divide by 4", tmr_pulse, i == 4);
      cyc();
    end
    tmr_tick = 1; cyc(); tmr_tick = 0; cyc();
    tmr_tick = 1; cyc(); tmr_tick = 0; cyc();
    clear_once();
    tmr_tick = 1; cyc(); tmr_tick = 0;
    chk(tmr_pulse == 0, "R8 count kept", tmr_pulse, 0);
    tmr_tick = 1; cyc(); tmr_tick = 0;
    chk(tmr_pulse == 1, "R8 clear ignored by timer prescaler", tmr_pulse, 1);
    cyc();
    psc_to_wd = 1;
    tmr_tick = 1; cyc(); tmr_tick = 0;
    chk(tmr_pulse == 1, "R10 bypass follows tick", tmr_pulse, 1);
    cyc();
    chk(tmr_pulse == 0, "R10 bypass idle", tmr_pulse, 0);

    // R1: power-on reset after a timeout
    psc_to_wd = 0; clear_once();
    count_ticks(n);
    por_n = 0; #1;
    chk(to_n == 1 && !rst_req, "R1 reset restores flag", to_n, 1);
    cyc(); por_n = 1; cyc();
    chk(to_n == 1 && !rst_req && !wake_req, "R1 idle after reset", to_n, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule